// File: doc/BRIEF.md
# DRAM Suspend Self-Refresh Sequencer

This block sits in a memory controller and takes an EDO DRAM from normal operation into self-refresh before the system suspends. In normal operation a programmable down-counter issues one CAS-before-RAS refresh request per interval. The interval is set through a count register that resets to its longest value. Software starts the suspend sequence by writing the suspend bit of the control word. If burst refresh is configured, the block first runs a fixed-length burst refresh. It then asks the DRAM timing engine to enter self-refresh and waits for that engine's acknowledge. Once the acknowledge arrives, it raises a status flag saying the memory clock may be stopped.

Each later stage needs its own software write, and a write that arrives early is dropped. The clock-stop bit only takes effect once the ready flag is up, and it then drops the memory clock enable. The pin-hold bit only takes effect once the clock is stopped. It then freezes the DRAM interface outputs at the levels they had in the cycle of the write. The DRAM timing engine is outside the block: a level request (`sr_req`) and an acknowledge (`sr_ack`) stand in for it. Exit from self-refresh is a reset.

The sequencer has six states, with these codes on `seq_state`: IDLE=0, BURST_REFRESH=1, SR_ENTRY=2, SR_READY=3, CLK_STOPPED=4, LATCHED=5. The transitions are:
- IDLE goes to BURST_REFRESH on a suspend write when `burst_en`=1.
- IDLE goes to SR_ENTRY on a suspend write when `burst_en`=0.
- BURST_REFRESH goes to SR_ENTRY when the burst length has elapsed.
- SR_ENTRY goes to SR_READY on `sr_ack`.
- SR_READY goes to CLK_STOPPED on a clock-stop write.
- CLK_STOPPED goes to LATCHED on a pin-hold write.
- LATCHED stays put until reset.

Top module: `dram_suspend_seq`

## Requirements
- R1: After synchronous reset, `seq_state`=0, `ctl_status`=0, `mclk_en`=1, `sr_req`=0, `burst_active`=0, `rfsh_req`=0, and `dram_pins_out` follows `dram_pins_in`.
- R2: In IDLE, `rfsh_req` pulses once every N+1 cycles, where N is the refresh count. The count resets to 1023 (all ones, the longest interval). A `cnt_wr` write loads a new N and restarts the interval.
- R3: Each refresh request is one clock cycle per interval. No refresh request is issued once the sequencer has left IDLE.
- R4: A suspend write (`ctl_wdata` bit 0) in IDLE with `burst_en`=1 holds `burst_active` high for exactly BURST_CYC+BURST_EXTRA cycles (default 16383+64). `sr_req` rises in the cycle after the burst ends.
- R5: A suspend write in IDLE with `burst_en`=0 raises `sr_req` in the next cycle (`seq_state`=2), with no burst.
- R6: `sr_req` stays high until `sr_ack`. One cycle after `sr_ack`, `sr_req`=0, `seq_state`=3 and the ready flag (`ctl_status` bit 1) is 1. The ready flag then stays 1 until reset.
- R7: A clock-stop write (`ctl_wdata` bit 1) before SR_READY is ignored and `mclk_en` stays 1. In SR_READY it clears `mclk_en` one cycle later and sets `ctl_status` bit 2 (`seq_state`=4).
- R8: A pin-hold write (`ctl_wdata` bit 2) before CLK_STOPPED is ignored and the pins keep following the input. In CLK_STOPPED it sets `ctl_status` bit 3 (`seq_state`=5) and freezes `dram_pins_out` at the input value of the write cycle.
- R9: A suspend write outside IDLE is ignored. `ctl_status` bit 0 is 1 in every state other than IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 3 | Bit 0 suspend, bit 1 clock stop, bit 2 pin hold |
| cnt_wr | input | 1 | Refresh count write strobe |
| cnt_wdata | input | CNT_W | New refresh count |
| burst_en | input | 1 | Configuration: run burst refresh before self-refresh |
| sr_ack | input | 1 | Timing engine: self-refresh entered |
| dram_pins_in | input | PIN_W | Interface levels from the timing engine |
| rfsh_req | output | 1 | One-cycle distributed refresh request |
| burst_active | output | 1 | Burst refresh in progress |
| sr_req | output | 1 | Self-refresh entry request |
| mclk_en | output | 1 | Memory clock enable for the clock gate |
| dram_pins_out | output | PIN_W | Interface levels to the pads |
| ctl_status | output | 4 | {pin held, clock stopped, ready to stop clock, suspend busy} |
| seq_state | output | 3 | Sequencer state code |

## Verification
Some properties are checked on every cycle. A refresh request only follows a cycle in IDLE. The ready flag only rises after an acknowledge and never falls. The clock enable only falls once the ready flag is up. `sr_req` only rises from IDLE or from a burst. Held pins never change. Other behaviour only the bench's scenarios can show: the exact refresh period for several counts, the exact burst length, and that early clock-stop, pin-hold and repeated suspend writes are dropped.

// File: rtl/dss_pkg.sv
`timescale 1ns/1ps
package dss_pkg;

    typedef enum logic [2:0] {
        ST_IDLE        = 3'd0,
        ST_BURST       = 3'd1,
        ST_SR_ENTRY    = 3'd2,
        ST_SR_READY    = 3'd3,
        ST_CLK_STOPPED = 3'd4,
        ST_LATCHED     = 3'd5
    } seq_state_e;

    localparam int CTL_W       = 3;
    localparam int CTL_SUSPEND = 0;
    localparam int CTL_STOPCLK = 1;
    localparam int CTL_HOLD    = 2;

    localparam int STAT_W       = 4;
    localparam int STAT_BUSY    = 0;
    localparam int STAT_READY   = 1;
    localparam int STAT_STOPPED = 2;
    localparam int STAT_HELD    = 3;

endpackage

// File: rtl/dss_refresh_timer.sv
`timescale 1ns/1ps
module dss_refresh_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic             rfsh_req
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] remain_q;
    logic             at_zero;

    assign at_zero = (remain_q == '0);

    // interval register and down-counter
    always_ff @(posedge clk) begin
        if (rst) begin
            count_q  <= CNT_MAX;
            remain_q <= CNT_MAX;
        end else if (cnt_wr) begin
            count_q  <= cnt_wdata;
            remain_q <= cnt_wdata;
        end else if (en) begin
            if (at_zero) begin
                remain_q <= count_q;
            end else begin
                remain_q <= remain_q - 1'b1;
            end
        end
    end

    // one-cycle request per expiry
    always_ff @(posedge clk) begin
        if (rst) begin
            rfsh_req <= 1'b0;
        end else begin
            rfsh_req <= en && at_zero && !cnt_wr;
        end
    end

endmodule

// File: rtl/dss_burst_counter.sv
`timescale 1ns/1ps
module dss_burst_counter #(
    parameter int BURST_CYC   = 16383,
    parameter int BURST_EXTRA = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int TOTAL = BURST_CYC + BURST_EXTRA;
    localparam int BW    = $clog2(TOTAL + 1);
    localparam logic [BW-1:0] LAST = BW'(TOTAL - 1);

    logic [BW-1:0] elapsed_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            elapsed_q <= '0;
        end else if (elapsed_q != LAST) begin
            elapsed_q <= elapsed_q + 1'b1;
        end
    end

    assign done = run && (elapsed_q == LAST);

endmodule

// File: rtl/dss_fsm.sv
`timescale 1ns/1ps
module dss_fsm
    import dss_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             burst_en,
    input  logic             burst_done,
    input  logic             sr_ack,
    output seq_state_e       state,
    output logic             timer_en,
    output logic             burst_run,
    output logic             sr_req,
    output logic             mclk_en,
    output logic             pin_hold,
    output logic [STAT_W-1:0] status
);
    seq_state_e state_n;
    logic       wr_suspend;
    logic       wr_stopclk;
    logic       wr_hold;

    assign wr_suspend = ctl_wr && ctl_wdata[CTL_SUSPEND];
    assign wr_stopclk = ctl_wr && ctl_wdata[CTL_STOPCLK];
    assign wr_hold    = ctl_wr && ctl_wdata[CTL_HOLD];

    // next-state decode
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:        if (wr_suspend) state_n = burst_en ? ST_BURST : ST_SR_ENTRY;
            ST_BURST:       if (burst_done) state_n = ST_SR_ENTRY;
            ST_SR_ENTRY:    if (sr_ack)     state_n = ST_SR_READY;
            ST_SR_READY:    if (wr_stopclk) state_n = ST_CLK_STOPPED;
            ST_CLK_STOPPED: if (wr_hold)    state_n = ST_LATCHED;
            ST_LATCHED:     state_n = ST_LATCHED;
            default:        state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // Moore outputs
    always_comb begin
        timer_en  = 1'b0;
        burst_run = 1'b0;
        sr_req    = 1'b0;
        mclk_en   = 1'b1;
        pin_hold  = 1'b0;
        status    = '0;
        unique case (state)
            ST_IDLE: begin
                timer_en = 1'b1;
            end
            ST_BURST: begin
                burst_run         = 1'b1;
                status[STAT_BUSY] = 1'b1;
            end
            ST_SR_ENTRY: begin
                sr_req            = 1'b1;
                status[STAT_BUSY] = 1'b1;
            end
            ST_SR_READY: begin
                status[STAT_BUSY]  = 1'b1;
                status[STAT_READY] = 1'b1;
            end
            ST_CLK_STOPPED: begin
                mclk_en              = 1'b0;
                status[STAT_BUSY]    = 1'b1;
                status[STAT_READY]   = 1'b1;
                status[STAT_STOPPED] = 1'b1;
            end
            ST_LATCHED: begin
                mclk_en  = 1'b0;
                pin_hold = 1'b1;
                status   = '1;
            end
            default: begin
                timer_en = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dss_pin_hold.sv
`timescale 1ns/1ps
module dss_pin_hold #(
    parameter int PIN_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic [PIN_W-1:0] pins_in,
    output logic [PIN_W-1:0] pins_out
);
    for (genvar b = 0; b < PIN_W; b++) begin : g_bit
        logic cap_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                cap_q <= 1'b0;
            end else if (!hold) begin
                cap_q <= pins_in[b];
            end
        end
        assign pins_out[b] = hold ? cap_q : pins_in[b];
    end

endmodule

// File: rtl/dram_suspend_seq.sv
`timescale 1ns/1ps
module dram_suspend_seq
    import dss_pkg::*;
#(
    parameter int CNT_W       = 10,
    parameter int PIN_W       = 32,
    parameter int BURST_CYC   = 16383,
    parameter int BURST_EXTRA = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ctl_wr,
    input  logic [2:0]         ctl_wdata,
    input  logic               cnt_wr,
    input  logic [CNT_W-1:0]   cnt_wdata,
    input  logic               burst_en,
    input  logic               sr_ack,
    input  logic [PIN_W-1:0]   dram_pins_in,
    output logic               rfsh_req,
    output logic               burst_active,
    output logic               sr_req,
    output logic               mclk_en,
    output logic [PIN_W-1:0]   dram_pins_out,
    output logic [3:0]         ctl_status,
    output logic [2:0]         seq_state
);
    seq_state_e state;
    logic       timer_en;
    logic       burst_run;
    logic       burst_done;
    logic       pin_hold;

    dss_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .ctl_wr     (ctl_wr),
        .ctl_wdata  (ctl_wdata),
        .burst_en   (burst_en),
        .burst_done (burst_done),
        .sr_ack     (sr_ack),
        .state      (state),
        .timer_en   (timer_en),
        .burst_run  (burst_run),
        .sr_req     (sr_req),
        .mclk_en    (mclk_en),
        .pin_hold   (pin_hold),
        .status     (ctl_status)
    );

    dss_refresh_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .en        (timer_en),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (cnt_wdata),
        .rfsh_req  (rfsh_req)
    );

    dss_burst_counter #(
        .BURST_CYC   (BURST_CYC),
        .BURST_EXTRA (BURST_EXTRA)
    ) u_burst (
        .clk  (clk),
        .rst  (rst),
        .run  (burst_run),
        .done (burst_done)
    );

    dss_pin_hold #(.PIN_W(PIN_W)) u_pins (
        .clk      (clk),
        .rst      (rst),
        .hold     (pin_hold),
        .pins_in  (dram_pins_in),
        .pins_out (dram_pins_out)
    );

    assign burst_active = burst_run;
    assign seq_state    = state;

endmodule

// File: rtl/dss_checker.sv
`timescale 1ns/1ps
module dss_checker #(
    parameter int PIN_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             rfsh_req,
    input logic             burst_active,
    input logic             sr_req,
    input logic             sr_ack,
    input logic             mclk_en,
    input logic [3:0]       ctl_status,
    input logic [2:0]       seq_state,
    input logic [PIN_W-1:0] dram_pins_out
);
    assert_rfsh_idle_R3: assert property (@(posedge clk) disable iff (rst)
        rfsh_req |-> ($past(seq_state) == 3'd0));

    assert_sr_rise_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(sr_req) |-> ($past(burst_active) || ($past(seq_state) == 3'd0)));

    assert_burst_excl_R4: assert property (@(posedge clk) disable iff (rst)
        burst_active |-> !sr_req);

    assert_ready_rise_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_status[1]) |-> $past(sr_ack));

    assert_ready_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        ctl_status[1] |=> ctl_status[1]);

    assert_gate_order_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(mclk_en) |-> $past(ctl_status[1]));

    assert_pins_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        (ctl_status[3] && $past(ctl_status[3])) |-> $stable(dram_pins_out));

    assert_busy_R9: assert property (@(posedge clk) disable iff (rst)
        (seq_state != 3'd0) |-> ctl_status[0]);

endmodule

bind dram_suspend_seq dss_checker #(.PIN_W(PIN_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .rfsh_req      (rfsh_req),
    .burst_active  (burst_active),
    .sr_req        (sr_req),
    .sr_ack        (sr_ack),
    .mclk_en       (mclk_en),
    .ctl_status    (ctl_status),
    .seq_state     (seq_state),
    .dram_pins_out (dram_pins_out)
);

// File: tb/sim_dram_suspend_seq.sv
`timescale 1ns/1ps
module sim_dram_suspend_seq;
    localparam int CNT_W       = 10;
    localparam int PIN_W       = 32;
    localparam int BURST_CYC   = 16383;
    localparam int BURST_EXTRA = 64;
    localparam int BURST_TOTAL = BURST_CYC + BURST_EXTRA;
    localparam int WATCHDOG    = 150000;

    localparam logic [2:0] W_SUSP = 3'b001;
    localparam logic [2:0] W_STOP = 3'b010;
    localparam logic [2:0] W_HOLD = 3'b100;

    // refresh count, expected period
    localparam int NVEC = 5;
    localparam logic [20:0] RVEC [NVEC] = '{
        {10'd0,  11'd1},
        {10'd1,  11'd2},
        {10'd3,  11'd4},
        {10'd10, 11'd11},
        {10'd57, 11'd58}
    };

    logic             clk = 1'b0;
    logic             rst;
    logic             ctl_wr;
    logic [2:0]       ctl_wdata;
    logic             cnt_wr;
    logic [CNT_W-1:0] cnt_wdata;
    logic             burst_en;
    logic             sr_ack;
    logic [PIN_W-1:0] dram_pins_in;
    logic             rfsh_req;
    logic             burst_active;
    logic             sr_req;
    logic             mclk_en;
    logic [PIN_W-1:0] dram_pins_out;
    logic [3:0]       ctl_status;
    logic [2:0]       seq_state;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dram_suspend_seq #(
        .CNT_W(CNT_W), .PIN_W(PIN_W),
        .BURST_CYC(BURST_CYC), .BURST_EXTRA(BURST_EXTRA)
    ) u0 (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .burst_en(burst_en),
        .sr_ack(sr_ack), .dram_pins_in(dram_pins_in), .rfsh_req(rfsh_req),
        .burst_active(burst_active), .sr_req(sr_req), .mclk_en(mclk_en),
        .dram_pins_out(dram_pins_out), .ctl_status(ctl_status),
        .seq_state(seq_state)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [2:0] v);
        ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_wr = 1'b0; ctl_wdata = '0;
    endtask

    task automatic wr_cnt(input logic [CNT_W-1:0] v);
        cnt_wr = 1'b1; cnt_wdata = v;
        @(negedge clk);
        cnt_wr = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic measure_period(output int n);
        while (!rfsh_req) @(negedge clk);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!rfsh_req);
    endtask

    initial begin
        #(WATCHDOG * 8);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int per;
        int seen;
        rst = 1'b1; ctl_wr = 0; ctl_wdata = 0; cnt_wr = 0; cnt_wdata = 0;
        burst_en = 0; sr_ack = 0; dram_pins_in = 32'h1234_5678;
        @(negedge clk);
        do_reset();

        // R1 reset state
        chk("R1 state", 64'(seq_state), 0);
        chk("R1 status", 64'(ctl_status), 0);
        chk("R1 mclk_en", 64'(mclk_en), 1);
        chk("R1 sr_req", 64'(sr_req), 0);
        chk("R1 burst", 64'(burst_active), 0);
        chk("R1 pins", 64'(dram_pins_out), 64'h1234_5678);

        // R2 reset count gives the longest interval
        measure_period(per);
        chk("R2 reset period", 64'(per), 1024);

        // R2 R3 table of counts and periods
        for (int i = 0; i < NVEC; i++) begin
            wr_cnt(RVEC[i][20:11]);
            measure_period(per);
            chk("R2 period", 64'(per), 64'(RVEC[i][10:0]));
            if (RVEC[i][10:0] > 1) begin
                @(negedge clk);
                chk("R3 one-cycle pulse", 64'(rfsh_req), 0);
            end
        end

        // Scenario without burst
        wr_cnt(10'd3);
        wr_ctl(W_STOP);
        chk("R7 early stop ignored mclk", 64'(mclk_en), 1);
        chk("R7 early stop ignored state", 64'(seq_state), 0);
        wr_ctl(W_HOLD);
        dram_pins_in = 32'hAAAA_0001;
        @(negedge clk);
        chk("R8 early hold ignored", 64'(dram_pins_out), 64'hAAAA_0001);
        burst_en = 1'b0;
        wr_ctl(W_SUSP);
        chk("R5 sr_req", 64'(sr_req), 1);
        chk("R5 state", 64'(seq_state), 2);
        chk("R5 no burst", 64'(burst_active), 0);
        chk("R9 busy", 64'(ctl_status[0]), 1);
        seen = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (rfsh_req) seen++;
        end
        chk("R3 no refresh after IDLE", 64'(seen), 0);
        wr_ctl(W_STOP);
        chk("R7 stop in SR_ENTRY ignored", 64'(mclk_en), 1);
        wr_ctl(W_SUSP);
        chk("R9 suspend ignored", 64'(seq_state), 2);
        chk("R6 sr_req held", 64'(sr_req), 1);
        chk("R6 no ready yet", 64'(ctl_status[1]), 0);
        sr_ack = 1'b1;
        @(negedge clk);
        sr_ack = 1'b0;
        chk("R6 state", 64'(seq_state), 3);
        chk("R6 ready", 64'(ctl_status[1]), 1);
        chk("R6 sr_req drop", 64'(sr_req), 0);
        wr_ctl(W_HOLD);
        dram_pins_in = 32'hBBBB_0002;
        @(negedge clk);
        chk("R8 hold in SR_READY ignored", 64'(dram_pins_out), 64'hBBBB_0002);
        chk("R8 hold in SR_READY state", 64'(seq_state), 3);
        wr_ctl(W_STOP | W_HOLD);
        chk("R7 mclk stopped", 64'(mclk_en), 0);
        chk("R7 state", 64'(seq_state), 4);
        chk("R7 status", 64'(ctl_status), 64'h7);
        dram_pins_in = 32'hCAFE_F00D;
        wr_ctl(W_HOLD);
        dram_pins_in = 32'h0BAD_BEEF;
        @(negedge clk);
        chk("R8 frozen pins", 64'(dram_pins_out), 64'hCAFE_F00D);
        chk("R8 status", 64'(ctl_status), 64'hF);
        chk("R8 state", 64'(seq_state), 5);
        wr_ctl(W_SUSP);
        chk("R9 suspend in LATCHED ignored", 64'(seq_state), 5);
        chk("R6 ready sticky", 64'(ctl_status[1]), 1);

        // Scenario with burst refresh
        do_reset();
        chk("R1 state after second reset", 64'(seq_state), 0);
        chk("R1 pins released", 64'(dram_pins_out), 64'h0BAD_BEEF);
        burst_en = 1'b1;
        wr_ctl(W_SUSP);
        chk("R4 state", 64'(seq_state), 1);
        chk("R4 sr_req low during burst", 64'(sr_req), 0);
        per = 0;
        seen = 0;
        while (burst_active) begin
            per++;
            if (rfsh_req && per > 1) seen++;
            @(negedge clk);
        end
        chk("R4 burst length", 64'(per), 64'(BURST_TOTAL));
        chk("R3 no refresh in burst", 64'(seen), 0);
        chk("R4 sr_req after burst", 64'(sr_req), 1);
        chk("R4 state after burst", 64'(seq_state), 2);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule